// File: doc/BRIEF.md
# Cascadable Delayed Parity Checker

This block checks a parity bit sent by a memory controller against a data word that was captured earlier. On each rising clock edge it takes the XOR of the data bits. If either chip-select input was low on that same edge, the XOR and that qualifier travel down a short pipeline. When the controller's parity bit arrives on a later edge, the block combines it with the stored XOR. The result is registered as a partial-parity output. The same result drives an active-low error flag, which is held low for a fixed number of cycles.

A one-bit position input picks the arrival edge of the parity bit. The block can then stand alone, or it can be the front or back device of a pair. In a pair, both devices see the same data edge and the same chip selects. The front device's partial-parity output is wired to the back device's parity input, so the back device checks the parity of both data words together. The front device's error flag is not used in that arrangement.

The error flag is handled by a two-state machine. In state ST_CLEAR the flag is high. The transition "hit" moves ST_CLEAR to ST_FLAG and loads the hold counter; a hit is a qualified compare whose XOR is 1. In ST_FLAG the flag is low. The transition "rehit" stays in ST_FLAG and reloads the counter. The transition "count" stays in ST_FLAG and decrements the counter. The transition "expire" returns to ST_CLEAR when the counter is zero and no new hit occurs. An asynchronous reset forces ST_CLEAR.

Top module: `cascade_parity_chk`

## Requirements
- R1: On a qualified compare, the partial-parity output becomes the XOR of all 11 captured data bits and the parity input. The chip-select inputs do not enter this XOR.
- R2: A qualified compare whose XOR is 1 drives the error flag low on the same edge that updates the partial-parity output.
- R3: With the position input at 0 (front), data is captured on edge k and the parity input is sampled on edge k+1. Both outputs change on edge k+1, so a consumer on the same clock captures them on edge k+2.
- R4: With the position input at 1 (back), data is captured on edge k and the parity input is sampled on edge k+2. Both outputs change on edge k+2, so a consumer captures them on edge k+3.
- R5: In a front-to-back pair, the back device checks the parity of both data words against the front's parity input. An error is visible at the back's flag for capture three edges after the data edge.
- R6: Once the error flag goes low, it stays low for exactly two clock cycles, unless another error or a reset occurs first.
- R7: A new error while the flag is already low restarts the two-cycle hold.
- R8: A compare is qualified only if at least one chip select was low on the data edge. If both were high on that edge, the partial-parity output keeps its value and no new error is raised. A running hold still expires normally.
- R9: While reset is low, the partial-parity output is 0 and the error flag is 1. Reset also clears any held error and empties the alignment pipeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_a_n | input | 1 | First chip select, active low |
| cs_b_n | input | 1 | Second chip select, active low |
| data_in | input | 11 | Data bits covered by the parity check |
| par_in | input | 1 | Parity bit from the controller, or from the front device's partial-parity output |
| back_sel | input | 1 | 0 = front/standalone, 1 = back of pair |
| par_out | output | 1 | Registered partial-parity result |
| err_n | output | 1 | Error flag, active low, stretched |

## Verification
Each fault shows up at the outputs within a fixed and short time.

- A wrong pipeline stage or position select pairs the parity input with the wrong data word. This corrupts the partial-parity output on the first data pattern where the neighbouring words have different parity, which is one or two edges after the data edge.
- A lost or stuck chip-select qualifier appears as a partial-parity output that does not hold during a deselected word, or that holds during a selected one.
- A wrong hold count or a state machine that fails to restart appears as an error flag that rises one cycle too early or too late after a single fault or a pair of nearby faults.
- The front-to-back pair exposes any latency mismatch between the two positions, because the back device's flag then no longer matches the combined parity.

// File: rtl/pc_pkg.sv
package pc_pkg;

    // One pipeline slot: did a selected word arrive, and its data parity
    typedef struct packed {
        logic vld;
        logic par;
    } stage_t;

    // Error flag controller states
    typedef enum logic {
        ST_CLEAR = 1'b0,
        ST_FLAG  = 1'b1
    } flag_state_t;

    // Deepest alignment needed (back position waits two edges)
    localparam int ALIGN_DEPTH = 2;

endpackage

// File: rtl/pc_align.sv
module pc_align
    import pc_pkg::*;
#(
    parameter int DATA_W = 11,
    parameter int DEPTH  = ALIGN_DEPTH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              word_vld,
    input  logic              back_sel,
    output stage_t            tap_o
);

    stage_t stg [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        stage_t nxt;
        if (g == 0) begin : g_head
            assign nxt = '{vld: word_vld, par: ^data_in};
        end else begin : g_tail
            assign nxt = stg[g-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg[g] <= '0;
            end else begin
                stg[g] <= nxt;
            end
        end
    end

    // Front position compares against the newest slot, back against the last
    assign tap_o = back_sel ? stg[DEPTH-1] : stg[0];

endmodule

// File: rtl/pc_compare.sv
module pc_compare
    import pc_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  stage_t tap_i,
    input  logic   par_in,
    output logic   par_out,
    output logic   hit_o
);

    logic sum;
    logic par_q;

    assign sum   = tap_i.par ^ par_in;
    assign hit_o = tap_i.vld & sum;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= 1'b0;
        end else if (tap_i.vld) begin
            par_q <= sum;
        end
    end

    assign par_out = par_q;

endmodule

// File: rtl/pc_err_fsm.sv
module pc_err_fsm
    import pc_pkg::*;
#(
    parameter int HOLD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    output logic err_n
);

    localparam int CNT_W = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_CYC - 1);

    flag_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_CLEAR;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: hit, rehit, count, expire
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (hit_i) begin
                    state_d = ST_FLAG;
                    cnt_d   = RELOAD;
                end
            end
            ST_FLAG: begin
                if (hit_i) begin
                    cnt_d = RELOAD;
                end else if (cnt_q == '0) begin
                    state_d = ST_CLEAR;
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_CLEAR;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            ST_FLAG: err_n = 1'b0;
            default: err_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/cascade_parity_chk.sv
module cascade_parity_chk
    import pc_pkg::*;
#(
    parameter int DATA_W   = 11,
    parameter int HOLD_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_a_n,
    input  logic              cs_b_n,
    input  logic [DATA_W-1:0] data_in,
    input  logic              par_in,
    input  logic              back_sel,
    output logic              par_out,
    output logic              err_n
);

    logic   word_vld;
    stage_t tap;
    logic   hit;

    assign word_vld = ~(cs_a_n & cs_b_n);

    pc_align #(
        .DATA_W (DATA_W),
        .DEPTH  (ALIGN_DEPTH)
    ) u_align (
        .clk      (clk),
        .rst_n    (rst_n),
        .data_in  (data_in),
        .word_vld (word_vld),
        .back_sel (back_sel),
        .tap_o    (tap)
    );

    pc_compare u_cmp (
        .clk     (clk),
        .rst_n   (rst_n),
        .tap_i   (tap),
        .par_in  (par_in),
        .par_out (par_out),
        .hit_o   (hit)
    );

    pc_err_fsm #(
        .HOLD_CYC (HOLD_CYC)
    ) u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .hit_i (hit),
        .err_n (err_n)
    );

endmodule

// File: rtl/pc_checker.sv
module pc_checker #(
    parameter int DATA_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_a_n,
    input logic              cs_b_n,
    input logic [DATA_W-1:0] data_in,
    input logic              par_in,
    input logic              back_sel,
    input logic              par_out,
    input logic              err_n
);

    // R3: front result two captures after the data edge
    assert_front_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!back_sel && !(cs_a_n && cs_b_n)) |=> ##1
        (par_out == ((^$past(data_in, 2)) ^ $past(par_in))));

    // R4: back result three captures after the data edge
    assert_back_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (back_sel && !(cs_a_n && cs_b_n)) |=> ##2
        (par_out == ((^$past(data_in, 3)) ^ $past(par_in))));

    // R8: deselected word leaves the partial-parity output unchanged (front)
    assert_hold_front_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!back_sel && cs_a_n && cs_b_n) |=> ##1 $stable(par_out));

    // R8: same for the back position
    assert_hold_back_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (back_sel && cs_a_n && cs_b_n) |=> ##2 $stable(par_out));

    // R2: a qualified mismatch shows on the flag together with the output
    assert_flag_on_mismatch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!back_sel && !(cs_a_n && cs_b_n)) |=> ##1 (!par_out || !err_n));

    // R6: the flag never drops for a single cycle only
    assert_stretch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_n) |=> !err_n);

endmodule

bind cascade_parity_chk pc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_a_n   (cs_a_n),
    .cs_b_n   (cs_b_n),
    .data_in  (data_in),
    .par_in   (par_in),
    .back_sel (back_sel),
    .par_out  (par_out),
    .err_n    (err_n)
);

// File: tb/sim_cascade_parity_chk.sv
module sim_cascade_parity_chk;

    localparam int CLK_P  = 10;
    localparam int DW     = 11;
    localparam int NCYC   = 2300;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_a_n = 1'b1;
    logic          cs_b_n = 1'b1;
    logic [DW-1:0] fd = '0;
    logic [DW-1:0] bd = '0;
    logic          fpin = 1'b0;
    logic          f_ppo, f_err_n, b_ppo, b_err_n;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    // Front device (position 0)
    cascade_parity_chk #(.DATA_W(DW), .HOLD_CYC(2)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .data_in(fd), .par_in(fpin), .back_sel(1'b0),
        .par_out(f_ppo), .err_n(f_err_n)
    );

    // Back device (position 1), fed by the front partial parity
    cascade_parity_chk #(.DATA_W(DW), .HOLD_CYC(2)) u1 (
        .clk(clk), .rst_n(rst_n), .cs_a_n(cs_a_n), .cs_b_n(cs_b_n),
        .data_in(bd), .par_in(f_ppo), .back_sel(1'b1),
        .par_out(b_ppo), .err_n(b_err_n)
    );

    // Reference state, advanced once per edge from the requirements
    logic m_fppo = 0, m_ferr = 1, m_fv = 0, m_fp = 0;
    int   m_fcnt = 0;
    logic m_bppo = 0, m_berr = 1, m_bv1 = 0, m_bp1 = 0, m_bv2 = 0, m_bp2 = 0;
    int   m_bcnt = 0;

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // R6 / R7: two-cycle hold, restarted by each new error
    task automatic flag_step(inout logic flg, inout int cnt, input logic hit);
        if (hit) begin
            flg = 1'b0;
            cnt = 1;
        end else if (!flg) begin
            if (cnt > 0) cnt = cnt - 1;
            else flg = 1'b1;
        end
    endtask

    task automatic model_edge(input logic rst, input logic csv,
                              input logic [DW-1:0] f, input logic [DW-1:0] b,
                              input logic pin);
        logic old_fppo, s, hit;
        old_fppo = m_fppo;
        if (rst) begin
            m_fppo = 0; m_ferr = 1; m_fcnt = 0; m_fv = 0; m_fp = 0;
            m_bppo = 0; m_berr = 1; m_bcnt = 0;
            m_bv1 = 0; m_bp1 = 0; m_bv2 = 0; m_bp2 = 0;
        end else begin
            hit = 1'b0;
            if (m_fv) begin
                s = m_fp ^ pin;
                m_fppo = s;
                hit = s;
            end
            flag_step(m_ferr, m_fcnt, hit);
            hit = 1'b0;
            if (m_bv2) begin
                s = m_bp2 ^ old_fppo;
                m_bppo = s;
                hit = s;
            end
            flag_step(m_berr, m_bcnt, hit);
            m_bv2 = m_bv1; m_bp2 = m_bp1;
            m_bv1 = csv;   m_bp1 = ^b;
            m_fv  = csv;   m_fp  = ^f;
        end
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog expired: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin : stim
        logic [DW-1:0] prev_f, prev_b;
        logic          rst, csa, csb, fault;
        string         ptag_f, ptag_b;
        prev_f = '0;
        prev_b = '0;

        // R9: reset state before any edge is counted
        @(negedge clk);
        check_bit("R9 front par_out in reset", f_ppo, 1'b0);
        check_bit("R9 front err_n in reset", f_err_n, 1'b1);
        check_bit("R9 back par_out in reset", b_ppo, 1'b0);
        check_bit("R9 back err_n in reset", b_err_n, 1'b1);

        for (int i = 0; i < NCYC; i++) begin
            rst   = (i < 3) || (i >= 1500 && i < 1502);
            csa   = (i % 9 == 4) || (i % 9 == 5);
            csb   = (i % 4 == 0) || (i % 9 == 5);
            fault = (i % 17 == 0) || (i % 29 == 10) || (i % 29 == 12) ||
                    (i == 1499);
            fd    = DW'(i);
            bd    = DW'(i * 173 + 5);
            // Correct parity covers both words of the previous edge (R5)
            fpin  = (^prev_f) ^ (^prev_b) ^ fault;
            cs_a_n = csa;
            cs_b_n = csb;
            rst_n  = !rst;
            model_edge(rst, !(csa && csb), fd, bd, fpin);
            prev_f = fd;
            prev_b = bd;

            @(posedge clk);
            @(negedge clk);
            if (rst) begin
                ptag_f = "R9 front par_out";
                ptag_b = "R9 back par_out";
            end else begin
                ptag_f = "R1 R3 R8 front par_out";
                ptag_b = "R4 R5 R8 back par_out";
            end
            check_bit(ptag_f, f_ppo, m_fppo);
            check_bit(ptag_b, b_ppo, m_bppo);
            check_bit(rst ? "R9 front err_n" : "R2 R6 R7 front err_n", f_err_n, m_ferr);
            check_bit(rst ? "R9 back err_n" : "R2 R5 R6 R7 back err_n", b_err_n, m_berr);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule